// File: doc/BRIEF.md
# Tagged Synchronization Register File

This block is a register file in which every word carries a two-bit synchronization tag, so that concurrent processes sharing it can hand values to one another on a producer-consumer basis. An issue request names two source words and one destination word, each with its own mode. In one indivisible step the block tests all three tags. It then either grants the request, or refuses it and asks for a retry. On a grant it returns both operand values, raises the program-counter advance strobe and rewrites the tags. On a refusal the requesting process simply presents the same request again on its next turn.

A granted destination is held reserved while its result is being computed elsewhere. A separate write-back port later delivers the result, stores it and marks the word full. A third port, for supervisory use, overwrites tags directly. A reserved word is protected from that port and from the forcing issue modes unless the request is privileged.

Tag codes: empty = 0, full = 1, reserved = 2 (code 3 is unused). Source mode bits: bit 1 = force (skip the test), bit 0 = keep (leave the tag as it is instead of emptying it). Destination mode bits: bit 1 = force (skip the test), bit 0 = require full instead of empty.

Top module: `sfm_sync_regfile`

## Requirements
- R1: After reset every word is empty, and the grant, retry and write-back error outputs are low.
- R2: An issue with all modes 0 is granted only when both sources are full and the destination is empty. The cycle after any issue, exactly one of grant and retry is high. With no issue, neither is high.
- R3: A refused issue changes no tag.
- R4: On a grant, a source in a non-keep mode becomes empty and the destination becomes reserved (2). The operand outputs carry both source values in the cycle the grant is shown.
- R5: A write-back stores its data and makes the word full. If the word was not reserved just before, the error output is high in the following cycle, and the write-back is still performed.
- R6: A source with mode bit 0 set must still test full, but its tag is left unchanged on a grant.
- R7: A destination with mode 01 must test full instead of empty, and still becomes reserved on a grant.
- R8: A forced operand (mode bit 1 set) skips its test. It fails only when its word is reserved and the request is not privileged.
- R9: The override port writes the given tag. It is ignored when the word is reserved and the override is not privileged.
- R10: When both sources name one word, the word is tested against both source modes and written once: it becomes empty unless both modes keep. A destination equal to a source ends up reserved.
- R11: Within one cycle, the write-back applies first, then the override, then the issue, which sees both of them. This includes the operand value just written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_src_a | input | ADDR_W | First source word |
| iss_src_b | input | ADDR_W | Second source word |
| iss_dst | input | ADDR_W | Destination word |
| iss_mode_a | input | 2 | First source mode |
| iss_mode_b | input | 2 | Second source mode |
| iss_mode_d | input | 2 | Destination mode |
| iss_priv | input | 1 | Issue is privileged |
| wb_valid | input | 1 | Write-back present |
| wb_addr | input | ADDR_W | Write-back word |
| wb_data | input | DATA_W | Write-back value |
| ovr_valid | input | 1 | Tag override present |
| ovr_addr | input | ADDR_W | Override word |
| ovr_tag | input | 2 | Tag to store |
| ovr_priv | input | 1 | Override is privileged |
| iss_grant | output | 1 | Grant, program-counter advance strobe |
| iss_retry | output | 1 | Refusal, reattempt the same issue |
| op_a | output | DATA_W | First operand value on grant |
| op_b | output | DATA_W | Second operand value on grant |
| wb_err | output | 1 | Last write-back hit a word that was not reserved |

## Verification
The checks assume that the override tag is never the unused code 3, and that request inputs are held low while reset is active. The bench drives only the three defined tag codes and idles all valid strobes around reset. The check that a refused issue leaves the tags untouched is only claimed for cycles without a write-back or override, and the write-back-gives-full check only for cycles with no issue or override. In those other cycles the outcome depends on the ordering rule. The bench sweeps that rule separately, with a reference model that applies the same ordering.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    typedef enum logic [1:0] {
        TAG_EMPTY = 2'd0,
        TAG_FULL  = 2'd1,
        TAG_RSVD  = 2'd2,
        TAG_SPARE = 2'd3
    } tag_e;

    localparam int unsigned MODE_FORCE = 1;
    localparam int unsigned MODE_ALT   = 0;

    function automatic logic src_pass(tag_e t, logic [1:0] m, logic priv);
        if (m[MODE_FORCE]) begin
            return (t != TAG_RSVD) || priv;
        end
        return t == TAG_FULL;
    endfunction

    function automatic logic dst_pass(tag_e t, logic [1:0] m, logic priv);
        if (m[MODE_FORCE]) begin
            return (t != TAG_RSVD) || priv;
        end
        if (m[MODE_ALT]) begin
            return t == TAG_FULL;
        end
        return t == TAG_EMPTY;
    endfunction

endpackage

// File: rtl/sfm_tag_pre.sv
module sfm_tag_pre
    import sfm_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  tag_e [DEPTH-1:0]  tags_q,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              ovr_valid,
    input  logic [ADDR_W-1:0] ovr_addr,
    input  logic [1:0]        ovr_tag,
    input  logic              ovr_priv,
    output tag_e [DEPTH-1:0]  tags_mid,
    output logic              wb_err
);

    // Write-back lands first, the supervisory override second.
    always_comb begin
        tags_mid = tags_q;
        wb_err   = 1'b0;
        if (wb_valid) begin
            wb_err            = (tags_q[wb_addr] != TAG_RSVD);
            tags_mid[wb_addr] = TAG_FULL;
        end
        if (ovr_valid && ((tags_mid[ovr_addr] != TAG_RSVD) || ovr_priv)) begin
            tags_mid[ovr_addr] = tag_e'(ovr_tag);
        end
    end

endmodule

// File: rtl/sfm_issue_judge.sv
module sfm_issue_judge
    import sfm_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] src_b,
    input  logic [1:0]        mode_a,
    input  logic [1:0]        mode_b,
    input  logic [1:0]        mode_d,
    input  logic              priv,
    input  tag_e              tag_a,
    input  tag_e              tag_b,
    input  tag_e              tag_d,
    output logic              grant,
    output logic              wr_b,
    output tag_e              nxt_a,
    output tag_e              nxt_b
);

    logic same_ab;
    logic ok_a;
    logic ok_b;
    logic ok_d;

    always_comb begin
        same_ab = (src_a == src_b);
        ok_a    = src_pass(tag_a, mode_a, priv);
        ok_b    = src_pass(tag_b, mode_b, priv);
        ok_d    = dst_pass(tag_d, mode_d, priv);
        grant   = valid && ok_a && ok_b && ok_d;

        // An aliased source pair is written once, keeping only if both keep.
        if (same_ab) begin
            nxt_a = (mode_a[MODE_ALT] && mode_b[MODE_ALT]) ? tag_a : TAG_EMPTY;
        end else begin
            nxt_a = mode_a[MODE_ALT] ? tag_a : TAG_EMPTY;
        end
        nxt_b = mode_b[MODE_ALT] ? tag_b : TAG_EMPTY;
        wr_b  = !same_ab;
    end

endmodule

// File: rtl/sfm_data_store.sv
module sfm_data_store #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
        // Same-cycle write-back is forwarded to both read ports.
        rd_a = (wr_en && (wr_addr == rd_addr_a)) ? wr_data : mem_q[rd_addr_a];
        rd_b = (wr_en && (wr_addr == rd_addr_b)) ? wr_data : mem_q[rd_addr_b];
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/sfm_sync_regfile.sv
module sfm_sync_regfile
    import sfm_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_src_a,
    input  logic [ADDR_W-1:0] iss_src_b,
    input  logic [ADDR_W-1:0] iss_dst,
    input  logic [1:0]        iss_mode_a,
    input  logic [1:0]        iss_mode_b,
    input  logic [1:0]        iss_mode_d,
    input  logic              iss_priv,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              ovr_valid,
    input  logic [ADDR_W-1:0] ovr_addr,
    input  logic [1:0]        ovr_tag,
    input  logic              ovr_priv,
    output logic              iss_grant,
    output logic              iss_retry,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic              wb_err
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        tag_e [DEPTH-1:0]  tags;
        logic              grant;
        logic              retry;
        logic              wb_err;
        logic [DATA_W-1:0] op_a;
        logic [DATA_W-1:0] op_b;
    } state_t;

    state_t st_q;
    state_t st_d;

    tag_e [DEPTH-1:0]   tags_mid;
    logic               pre_err;
    logic               jd_grant;
    logic               jd_wr_b;
    tag_e               jd_nxt_a;
    tag_e               jd_nxt_b;
    logic [DATA_W-1:0]  rd_a;
    logic [DATA_W-1:0]  rd_b;
    logic [2*DEPTH-1:0] tag_view;

    sfm_tag_pre #(.ADDR_W(ADDR_W)) i_pre (
        .tags_q    (st_q.tags),
        .wb_valid  (wb_valid),
        .wb_addr   (wb_addr),
        .ovr_valid (ovr_valid),
        .ovr_addr  (ovr_addr),
        .ovr_tag   (ovr_tag),
        .ovr_priv  (ovr_priv),
        .tags_mid  (tags_mid),
        .wb_err    (pre_err)
    );

    sfm_issue_judge #(.ADDR_W(ADDR_W)) i_judge (
        .valid  (iss_valid),
        .src_a  (iss_src_a),
        .src_b  (iss_src_b),
        .mode_a (iss_mode_a),
        .mode_b (iss_mode_b),
        .mode_d (iss_mode_d),
        .priv   (iss_priv),
        .tag_a  (tags_mid[iss_src_a]),
        .tag_b  (tags_mid[iss_src_b]),
        .tag_d  (tags_mid[iss_dst]),
        .grant  (jd_grant),
        .wr_b   (jd_wr_b),
        .nxt_a  (jd_nxt_a),
        .nxt_b  (jd_nxt_b)
    );

    sfm_data_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk       (clk),
        .wr_en     (wb_valid),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data),
        .rd_addr_a (iss_src_a),
        .rd_addr_b (iss_src_b),
        .rd_a      (rd_a),
        .rd_b      (rd_b)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tags   = tags_mid;
        st_d.wb_err = pre_err;
        st_d.grant  = jd_grant;
        st_d.retry  = iss_valid && !jd_grant;
        if (jd_grant) begin
            st_d.tags[iss_src_a] = jd_nxt_a;
            if (jd_wr_b) begin
                st_d.tags[iss_src_b] = jd_nxt_b;
            end
            // Destination written last so it wins over an aliased source.
            st_d.tags[iss_dst] = TAG_RSVD;
            st_d.op_a          = rd_a;
            st_d.op_b          = rd_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_view  = st_q.tags;
    assign iss_grant = st_q.grant;
    assign iss_retry = st_q.retry;
    assign op_a      = st_q.op_a;
    assign op_b      = st_q.op_b;
    assign wb_err    = st_q.wb_err;

endmodule

// File: rtl/sfm_sync_checker.sv
module sfm_sync_checker #(
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic [ADDR_W-1:0]  iss_src_a,
    input logic [ADDR_W-1:0]  iss_dst,
    input logic [1:0]         iss_mode_a,
    input logic               wb_valid,
    input logic [ADDR_W-1:0]  wb_addr,
    input logic               ovr_valid,
    input logic               iss_grant,
    input logic               iss_retry,
    input logic               wb_err,
    input logic [2*DEPTH-1:0] tag_view
);

    logic [ADDR_W-1:0]  src_a_p;
    logic [ADDR_W-1:0]  dst_p;
    logic [1:0]         mode_a_p;
    logic [ADDR_W-1:0]  wb_addr_p;
    logic               wbv_p;
    logic               ovrv_p;
    logic               issv_p;
    logic [2*DEPTH-1:0] tags_p;

    always_ff @(posedge clk) begin
        src_a_p   <= iss_src_a;
        dst_p     <= iss_dst;
        mode_a_p  <= iss_mode_a;
        wb_addr_p <= wb_addr;
        wbv_p     <= wb_valid;
        ovrv_p    <= ovr_valid;
        issv_p    <= iss_valid;
        tags_p    <= tag_view;
    end

    p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (iss_grant != iss_retry));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> (!iss_grant && !iss_retry));

    p_refuse_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_retry && !wbv_p && !ovrv_p) |-> (tag_view == tags_p));

    p_dst_rsvd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> (tag_view[2*dst_p +: 2] == 2'd2));

    p_src_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant && (mode_a_p == 2'b00) && (src_a_p != dst_p))
            |-> (tag_view[2*src_a_p +: 2] == 2'd0));

    p_wb_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wbv_p && !ovrv_p && !issv_p) |-> (tag_view[2*wb_addr_p +: 2] == 2'd1));

    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> wbv_p);

endmodule

bind sfm_sync_regfile sfm_sync_checker #(.ADDR_W(ADDR_W)) i_sfm_chk (.*);

// File: tb/test_sfm_sync_regfile.sv
module test_sfm_sync_regfile;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int N  = 1 << AW;
    localparam logic [AW-1:0] SCR = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [AW-1:0] iss_src_a = '0;
    logic [AW-1:0] iss_src_b = '0;
    logic [AW-1:0] iss_dst = '0;
    logic [1:0]    iss_mode_a = '0;
    logic [1:0]    iss_mode_b = '0;
    logic [1:0]    iss_mode_d = '0;
    logic          iss_priv = 1'b0;
    logic          wb_valid = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic [DW-1:0] wb_data = '0;
    logic          ovr_valid = 1'b0;
    logic [AW-1:0] ovr_addr = '0;
    logic [1:0]    ovr_tag = '0;
    logic          ovr_priv = 1'b0;
    logic          iss_grant;
    logic          iss_retry;
    logic [DW-1:0] op_a;
    logic [DW-1:0] op_b;
    logic          wb_err;

    always #10 clk = ~clk;

    sfm_sync_regfile #(.ADDR_W(AW), .DATA_W(DW)) i_sfm_sync_regfile (.*);

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    bit  last_g = 0;
    logic [1:0]    mt   [N];
    logic [DW-1:0] mdat [N];

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit s_ok(logic [1:0] t, logic [1:0] m, bit p);
        if (m[1]) return (t != 2'd2) || p;
        return t == 2'd1;
    endfunction

    function automatic bit d_ok(logic [1:0] t, logic [1:0] m, bit p);
        if (m[1]) return (t != 2'd2) || p;
        if (m[0]) return t == 2'd1;
        return t == 2'd0;
    endfunction

    task automatic run_cycle(string req);
        logic [1:0]    mid [N];
        bit            e_err;
        bit            e_g;
        bit            e_r;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        mid   = mt;
        e_err = 1'b0;
        if (wb_valid) begin
            e_err = (mt[wb_addr] != 2'd2);
            mid[wb_addr] = 2'd1;
            mdat[wb_addr] = wb_data;
        end
        if (ovr_valid && ((mid[ovr_addr] != 2'd2) || ovr_priv)) mid[ovr_addr] = ovr_tag;
        e_g = iss_valid && s_ok(mid[iss_src_a], iss_mode_a, iss_priv)
                        && s_ok(mid[iss_src_b], iss_mode_b, iss_priv)
                        && d_ok(mid[iss_dst], iss_mode_d, iss_priv);
        e_r = iss_valid && !e_g;
        ea  = mdat[iss_src_a];
        eb  = mdat[iss_src_b];
        if (e_g) begin
            if (iss_src_a == iss_src_b) begin
                if (!(iss_mode_a[0] && iss_mode_b[0])) mid[iss_src_a] = 2'd0;
            end else begin
                if (!iss_mode_a[0]) mid[iss_src_a] = 2'd0;
                if (!iss_mode_b[0]) mid[iss_src_b] = 2'd0;
            end
            mid[iss_dst] = 2'd2;
        end
        mt = mid;
        last_g = e_g;
        @(posedge clk);
        @(negedge clk);
        chk(req, "grant", {15'd0, iss_grant}, {15'd0, e_g});
        chk(req, "retry", {15'd0, iss_retry}, {15'd0, e_r});
        if (e_g && !$isunknown(ea)) chk(req, "op_a", op_a, ea);
        if (e_g && !$isunknown(eb)) chk(req, "op_b", op_b, eb);
        chk("R5", "wb_err", {15'd0, wb_err}, {15'd0, e_err});
        iss_valid = 1'b0;
        wb_valid  = 1'b0;
        ovr_valid = 1'b0;
    endtask

    task automatic setup_word(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] t);
        wb_valid = 1'b1; wb_addr = a; wb_data = d;
        ovr_valid = 1'b1; ovr_addr = a; ovr_tag = t; ovr_priv = 1'b1;
        run_cycle("R5");
    endtask

    task automatic issue(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] d,
                         logic [1:0] ma, logic [1:0] mb, logic [1:0] mdd, bit p, string req);
        iss_valid = 1'b1; iss_src_a = a; iss_src_b = b; iss_dst = d;
        iss_mode_a = ma; iss_mode_b = mb; iss_mode_d = mdd; iss_priv = p;
        run_cycle(req);
    endtask

    // First probe grants only if the word is full, second only if empty.
    task automatic probe(logic [AW-1:0] x, string req);
        issue(x, x, SCR, 2'b01, 2'b01, 2'b10, 1'b1, req);
        issue(SCR, SCR, x, 2'b11, 2'b11, 2'b00, 1'b1, req);
    endtask

    task automatic override(logic [AW-1:0] a, logic [1:0] t, bit p);
        ovr_valid = 1'b1; ovr_addr = a; ovr_tag = t; ovr_priv = p;
        run_cycle("R9");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mt[i] = 2'd0;
            mdat[i] = 'x;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "grant", {15'd0, iss_grant}, 16'd0);
        chk("R1", "retry", {15'd0, iss_retry}, 16'd0);
        chk("R1", "wb_err", {15'd0, wb_err}, 16'd0);
        issue(3'd4, 3'd4, SCR, 2'b01, 2'b01, 2'b10, 1'b1, "R1");
        issue(SCR, SCR, 3'd5, 2'b11, 2'b11, 2'b00, 1'b1, "R1");
        issue(3'd1, 3'd2, 3'd3, 2'b00, 2'b00, 2'b00, 1'b0, "R1");

        // R9: override port, reserved protection
        override(3'd3, 2'd2, 1'b1);
        override(3'd3, 2'd1, 1'b0);
        probe(3'd3, "R9");
        override(3'd6, 2'd1, 1'b0);
        probe(3'd6, "R9");
        override(3'd6, 2'd2, 1'b0);
        override(3'd6, 2'd0, 1'b1);
        probe(3'd6, "R9");

        // R11: same-cycle ordering and operand forwarding
        setup_word(3'd4, 16'h1111, 2'd2);
        setup_word(3'd5, 16'h2222, 2'd1);
        setup_word(3'd6, 16'h3333, 2'd0);
        wb_valid = 1'b1; wb_addr = 3'd4; wb_data = 16'hBEEF;
        issue(3'd4, 3'd5, 3'd6, 2'b00, 2'b00, 2'b00, 1'b0, "R11");
        setup_word(3'd4, 16'h4444, 2'd1);
        setup_word(3'd5, 16'h5555, 2'd1);
        setup_word(3'd6, 16'h6666, 2'd0);
        ovr_valid = 1'b1; ovr_addr = 3'd6; ovr_tag = 2'd1; ovr_priv = 1'b0;
        issue(3'd4, 3'd5, 3'd6, 2'b00, 2'b00, 2'b00, 1'b0, "R11");
        probe(3'd4, "R11");

        // Sweep: alias pattern x privilege x tags x modes
        for (int pat = 0; pat < 3; pat++) begin
            for (int p = 0; p < 2; p++) begin
                for (int tc = 0; tc < 27; tc++) begin
                    for (int mc = 0; mc < 64; mc++) begin
                        logic [AW-1:0] a, b, d;
                        logic [1:0] ma, mb, mdd;
                        string req;
                        a = 3'd0;
                        b = (pat == 1) ? 3'd0 : 3'd1;
                        d = (pat == 2) ? 3'd0 : 3'd2;
                        ma  = mc[1:0];
                        mb  = mc[3:2];
                        mdd = mc[5:4];
                        setup_word(3'd0, 16'(16'hA000 + tc * 64 + mc), 2'(tc % 3));
                        setup_word(3'd1, 16'(16'hB000 + tc * 64 + mc), 2'((tc / 3) % 3));
                        setup_word(3'd2, 16'(16'hC000 + tc * 64 + mc), 2'(tc / 9));
                        if (pat != 0) req = "R10";
                        else if (ma[1] || mb[1] || mdd[1]) req = "R8";
                        else if (ma[0] || mb[0]) req = "R6";
                        else if (mdd[0]) req = "R7";
                        else req = "R2";
                        issue(a, b, d, ma, mb, mdd, p[0], req);
                        req = last_g ? "R4" : "R3";
                        probe(3'd0, req);
                        probe(3'd1, req);
                        probe(3'd2, req);
                    end
                end
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule